// File: doc/BRIEF.md
# Sorting-Network Population Counter

This block counts the set bits of a data word without an adder tree. The word first passes through a fixed network of single-bit compare-exchange cells in an odd-even transposition arrangement. Each cell is an OR gate that drives the side collecting ones and an AND gate that drives the side collecting zeros. After as many stages as there are bits, every one bit sits at the low-index end. The result is a thermometer (unary) code.

A boundary detector then compares each pair of neighbouring sorted bits. It pads the low end with a constant one and the high end with a constant zero, which gives a one-hot word with one more position than the input has bits. An encoder ORs the one-hot lines into a binary count.

The sorted word is also a block output, so a neighbour can compare two such unary words directly. The block is purely combinational.

Top module: `popsort_counter`

## Requirements
- R1: `sorted_o` contains exactly as many one bits as `data_i`.
- R2: `sorted_o` is a thermometer code with the ones at the low end. With c set bits in `data_i`, bits 0 to c-1 of `sorted_o` are 1 and every higher bit is 0.
- R3: `count_o` is the unsigned binary number of set bits in `data_i`, from 0 to WIDTH. It is 5 bits wide for the default WIDTH of 16.
- R4: An all-zero `data_i` gives `sorted_o` = 0 and `count_o` = 0.
- R5: An all-ones `data_i` gives `sorted_o` with all bits set and `count_o` = WIDTH (16, binary 10000).
- R6: A `data_i` with a single set bit at any position gives `sorted_o` = 1 (only bit 0 set) and `count_o` = 1.
- R7: Both outputs follow a change of `data_i` within the same clock period, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word whose set bits are counted |
| sorted_o | output | WIDTH | Input bits rearranged with all ones at the low end |
| count_o | output | CNT_W | Binary number of set bits in `data_i` |

## Verification
The all-zero word and the all-ones word check the two end positions of the one-hot boundary: the padding constants, and the top encoder line that only a count of WIDTH reaches.

The sixteen single-bit words show whether a one can travel from any lane down to lane 0. A missing or misplaced compare-exchange cell at some depth would strand it.

Fixed-seed random words, and a pair of words with sparse and alternating bits, exercise the middle counts. There, a wrong stage parity or a faulty encoder bit shows up as a wrong count or a broken thermometer.

// File: rtl/popsort_pkg.sv
package popsort_pkg;

   // Number of bits needed to hold a count from 0 to n inclusive.
   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/popsort_cx_cell.sv
// Single-bit compare-exchange: the ones side takes OR, the zeros side takes AND.
module popsort_cx_cell (
   input  logic a_i,
   input  logic b_i,
   output logic one_o,
   output logic zero_o
);
   assign one_o  = a_i | b_i;
   assign zero_o = a_i & b_i;
endmodule

// File: rtl/popsort_oet_net.sv
// Odd-even transposition network. Stage s pairs lanes (i, i+1) with i of the
// same parity as s. The OR result goes to the lower lane.
module popsort_oet_net #(
   parameter int WIDTH  = 16,
   parameter int STAGES = WIDTH
) (
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] dout_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("popsort_oet_net: WIDTH must be at least 2");
   end
   if (STAGES < WIDTH) begin : g_bad_stages
      $error("popsort_oet_net: STAGES below WIDTH cannot sort every word");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      localparam int PAR = s % 2;
      logic [WIDTH-1:0] prv;
      logic [WIDTH-1:0] nxt;

      if (s == 0) begin : g_src_in
         assign prv = din_i;
      end else begin : g_src_stg
         assign prv = g_stg[s-1].nxt;
      end

      for (genvar i = 0; i < WIDTH; i++) begin : g_lane
         localparam bit IS_LO = (i >= PAR) && (((i - PAR) % 2) == 0) && (i + 1 < WIDTH);
         localparam bit IS_HI = (i >= PAR + 1) && (((i - 1 - PAR) % 2) == 0);
         if (IS_LO) begin : g_cell
            popsort_cx_cell u_cx (
               .a_i   (prv[i]),
               .b_i   (prv[i+1]),
               .one_o (nxt[i]),
               .zero_o(nxt[i+1])
            );
         end else if (!IS_HI) begin : g_pass
            assign nxt[i] = prv[i];
         end
      end
   end

   assign dout_o = g_stg[STAGES-1].nxt;

   // The network neither creates nor destroys ones.
   always_comb begin
      p_conserve_r1 : assert ($countones(dout_o) == $countones(din_i))
         else $error("R1: sorter changed the number of ones");
   end
endmodule

// File: rtl/popsort_boundary.sv
// Thermometer to one-hot: hot[k] = t[k-1] & ~t[k], with t[-1]=1 and t[WIDTH]=0.
module popsort_boundary #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] therm_i,
   output logic [WIDTH:0]   hot_o
);
   localparam int PW = WIDTH + 2;
   logic [PW-1:0] padded;

   assign padded = {1'b0, therm_i, 1'b1};

   for (genvar k = 0; k <= WIDTH; k++) begin : g_edge
      assign hot_o[k] = padded[k] & ~padded[k+1];
   end

   // A clean thermometer input leaves exactly one boundary.
   always_comb begin
      p_onehot_r3 : assert ($onehot(hot_o))
         else $error("R3: boundary code is not one-hot");
   end
endmodule

// File: rtl/popsort_encoder.sv
// One-hot to binary: count bit b is the OR of every hot line whose index has bit b set.
module popsort_encoder #(
   parameter int LINES = 17,
   parameter int OUT_W = 5
) (
   input  logic [LINES-1:0] hot_i,
   output logic [OUT_W-1:0] bin_o
);
   if ((1 << OUT_W) < LINES) begin : g_bad_out
      $error("popsort_encoder: OUT_W too narrow for LINES");
   end

   for (genvar b = 0; b < OUT_W; b++) begin : g_bit
      logic [LINES-1:0] sel;
      for (genvar k = 0; k < LINES; k++) begin : g_line
         if (((k >> b) & 1) == 1) begin : g_on
            assign sel[k] = hot_i[k];
         end else begin : g_off
            assign sel[k] = 1'b0;
         end
      end
      assign bin_o[b] = |sel;
   end

   // Line 0 alone is the zero count.
   always_comb begin
      p_zero_r4 : assert (hot_i[0] == (bin_o == '0) || !$onehot(hot_i))
         else $error("R4: zero line and zero count disagree");
   end
endmodule

// File: rtl/popsort_counter.sv
module popsort_counter
   import popsort_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int CNT_W = cnt_width(WIDTH)
) (
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] sorted_o,
   output logic [CNT_W-1:0] count_o
);
   localparam int LINES = WIDTH + 1;

   if (CNT_W < cnt_width(WIDTH)) begin : g_bad_cnt
      $error("popsort_counter: CNT_W cannot hold WIDTH");
   end

   logic [LINES-1:0] hot;

   popsort_oet_net #(.WIDTH(WIDTH), .STAGES(WIDTH)) u_net (
      .din_i (data_i),
      .dout_o(sorted_o)
   );

   popsort_boundary #(.WIDTH(WIDTH)) u_bnd (
      .therm_i(sorted_o),
      .hot_o  (hot)
   );

   popsort_encoder #(.LINES(LINES), .OUT_W(CNT_W)) u_enc (
      .hot_i(hot),
      .bin_o(count_o)
   );

   always_comb begin
      p_count_r3 : assert (int'(count_o) == $countones(data_i))
         else $error("R3: count does not match input population");
      p_therm_r2 : assert (($countones(sorted_o) == 0) ||
                           (sorted_o[0] && ((sorted_o & (sorted_o + 1'b1)) == '0)))
         else $error("R2: sorted word is not a low-end thermometer");
   end
endmodule

// File: tb/popsort_counter_tb_top.sv
`timescale 1ns/1ps
module popsort_counter_tb_top;
   localparam int W  = 16;
   localparam int CW = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;   // 125 MHz

   logic [W-1:0]  data;
   logic [W-1:0]  sorted;
   logic [CW-1:0] count;

   int vectors = 0;
   int errors  = 0;

   popsort_counter #(.WIDTH(W)) dut_i (
      .data_i  (data),
      .sorted_o(sorted),
      .count_o (count)
   );

   function automatic int ref_count(input logic [W-1:0] v);
      int c = 0;
      for (int i = 0; i < W; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic logic [W-1:0] ref_sorted(input int c);
      logic [W-1:0] r = '0;
      for (int i = 0; i < c; i++) r[i] = 1'b1;
      return r;
   endfunction

   // Drive after a falling edge, sample before the next rising edge (R7).
   task automatic apply(input logic [W-1:0] v, input string req);
      int c;
      @(negedge clk);
      data = v;
      #2;
      c = ref_count(v);
      vectors++;
      if (sorted !== ref_sorted(c)) begin
         errors++;
         $display("FAIL %s/R2 sorted in=%h got=%h exp=%h", req, v, sorted, ref_sorted(c));
      end
      if (int'(count) != c || $isunknown(count)) begin
         errors++;
         $display("FAIL %s/R3 count in=%h got=%0d exp=%0d", req, v, count, c);
      end
      if ($countones(sorted) != c) begin
         errors++;
         $display("FAIL %s/R1 ones in=%h got=%0d exp=%0d", req, v, $countones(sorted), c);
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired got=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      data = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      apply('0, "R4");                       // reset state / all zero
      apply('1, "R5");                       // all ones, count 16
      for (int i = 0; i < W; i++) apply(W'(1) << i, "R6");
      apply(16'h2222, "R7");                 // sparse word
      apply(16'hAAAA, "R7");                 // alternating word
      apply(16'h7FFF, "R3");
      apply(16'hFFFE, "R3");
      void'($urandom(32'h5EED_0042));
      for (int n = 0; n < 500; n++) apply(W'($urandom), "R3");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule